// File: doc/BRIEF.md
# Maskable Interrupt Flag Register

This unit gathers single-cycle event pulses from four sources (timer A underflow, timer B underflow, time-of-day alarm, serial data register) into a byte-wide flag register. It also holds a seven-bit enable mask and drives one active-low interrupt request. A processor reads the flag byte to find out which events happened. That read also acknowledges them. The processor writes the same address to change the mask.

Every event is recorded whether or not its source is enabled. Only enabled sources raise the request and the summary bit (bit 7 of the read byte). The summary and the request stay set until a read, even if the mask later loses the bit that caused them. A mask write that enables a source whose flag is already set raises the request at once.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset the mask and all flags are zero, `rdata` reads 0x00 and `irq_n` is 1.
- R2: A pulse on `evt[0]`, `evt[1]`, `evt[2]` or `evt[3]` (timer A, timer B, alarm, serial) sets `rdata` bit 0, 1, 2 or 3 at the next clock edge. The bit holds until a read.
- R3: An event whose mask bit is 0 still sets its flag, but it leaves `rdata` bit 7 at 0 and `irq_n` at 1.
- R4: A write with `wdata[7]`=1 ORs `wdata[6:0]` into the mask and leaves the other mask bits unchanged.
- R5: A write with `wdata[7]`=0 clears each mask bit whose `wdata` bit is 1 and leaves the other mask bits unchanged.
- R6: An event whose mask bit is 1 sets `rdata` bit 7 and drives `irq_n` low at the next clock edge.
- R7: A mask write that enables a source whose flag is already set sets `rdata` bit 7 and drives `irq_n` low at that write's clock edge.
- R8: While `rd_en` is high, `rdata` shows all flags including bit 7. At that clock edge all flags clear and `irq_n` returns to 1.
- R9: An event pulse in the same cycle as a read is not lost. Its flag, and bit 7 with the request if it is enabled, are set after that edge.
- R10: Once `irq_n` is low it stays low until a read, even if a later write clears the mask bit that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe. Acknowledges and clears the flags at the clock edge |
| wr_en | input | 1 | Mask write strobe |
| wdata | input | 8 | Write data. Bit 7 selects set (1) or clear (0); bits 6:0 select mask bits |
| evt | input | SRC_N | One-cycle event pulses. Bit 0 timer A, 1 timer B, 2 alarm, 3 serial |
| rdata | output | 8 | Bit 7 is the summary; bits 6:0 are the event flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
All state is registered, and `rdata` and `irq_n` come straight from the registers. An event pulse or mask write shows up one clock edge later. A read shows the old flags during its own cycle, and the cleared value appears one edge later. The bench drives inputs just after a falling edge and samples them at the next falling edge: once during a read for the returned value, and once after the edge for every updated value. It never samples inside the cycle that produces a result. It sweeps every mask and event combination over the four sources.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = DATA_W - 1;

    typedef enum int unsigned {
        SRC_TMR_A  = 0,
        SRC_TMR_B  = 1,
        SRC_ALARM  = 2,
        SRC_SERIAL = 3
    } src_idx_e;

    typedef struct packed {
        logic              req;
        logic [FLAG_W-1:0] flags;
    } status_t;

    // Top data bit chooses set (1) or clear (0) of the selected mask bits
    function automatic logic [FLAG_W-1:0] mask_update(
        input logic [FLAG_W-1:0] cur,
        input logic [DATA_W-1:0] d
    );
        if (d[DATA_W-1]) return cur | d[FLAG_W-1:0];
        else             return cur & ~d[FLAG_W-1:0];
    endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [FLAG_W-1:0] mask_q,
    output logic [FLAG_W-1:0] mask_nxt
);
    always_comb begin
        mask_nxt = wr_en ? mask_update(mask_q, wdata) : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_nxt;
    end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import evt_irq_pkg::*;
#(
    parameter int SRC_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [FLAG_W-1:0] evt_ext,
    output logic [FLAG_W-1:0] flags_q,
    output logic [FLAG_W-1:0] flags_nxt
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (i < SRC_N) begin : g_live
            // A read clears the old value; a new pulse in that cycle survives
            assign flags_nxt[i] = (flags_q[i] & ~rd_en) | evt_ext[i];
            always_ff @(posedge clk) begin
                if (rst) flags_q[i] <= 1'b0;
                else     flags_q[i] <= flags_nxt[i];
            end
        end else begin : g_unused
            assign flags_nxt[i] = 1'b0;
            assign flags_q[i]   = 1'b0;
        end
    end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen (
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    input  logic evt_hit,
    input  logic pend_hit,
    output logic req_q
);
    logic req_nxt;

    always_comb begin
        req_nxt = (req_q & ~rd_en) | evt_hit | pend_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_nxt;
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int SRC_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic [SRC_N-1:0]  evt,
    output logic [7:0]        rdata,
    output logic              irq_n
);
    logic [FLAG_W-1:0] evt_ext;
    logic [FLAG_W-1:0] mask_q, mask_nxt;
    logic [FLAG_W-1:0] flags_q, flags_nxt;
    logic              evt_hit, pend_hit, req_q;
    status_t           stat;

    assign evt_ext = FLAG_W'(evt);

    irq_mask_reg u_mask (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt)
    );

    irq_flag_reg #(.SRC_N(SRC_N)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .evt_ext   (evt_ext),
        .flags_q   (flags_q),
        .flags_nxt (flags_nxt)
    );

    assign evt_hit  = |(evt_ext & mask_nxt);
    assign pend_hit = wr_en & (|(flags_nxt & mask_nxt));

    irq_req_gen u_req (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .evt_hit  (evt_hit),
        .pend_hit (pend_hit),
        .req_q    (req_q)
    );

    assign stat.req   = req_q;
    assign stat.flags = flags_q;
    assign rdata      = stat;
    assign irq_n      = ~req_q;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
    parameter int SRC_N = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             wr_en,
    input logic [7:0]       wdata,
    input logic [SRC_N-1:0] evt,
    input logic [6:0]       mask_q,
    input logic [7:0]       rdata,
    input logic             irq_n
);
    logic [6:0] evt_w;
    assign evt_w = 7'(evt);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (rdata == 8'h00 && irq_n && mask_q == 7'h00));

    assert_flag_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((rdata[6:0] & $past(evt_w)) == $past(evt_w)));

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_n && !wr_en && ((evt_w & mask_q) == 7'h00)) |=> irq_n);

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[7]) |=> ((mask_q & $past(wdata[6:0])) == $past(wdata[6:0])));

    assert_mask_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdata[7]) |=> ((mask_q & $past(wdata[6:0])) == 7'h00));

    assert_enabled_event_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && ((evt_w & mask_q) != 7'h00)) |=> (!irq_n && rdata[7]));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && evt == '0 && !wr_en) |=> (rdata == 8'h00 && irq_n));

    assert_event_survives_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && evt != '0) |=> (rdata[6:0] == $past(evt_w)));

    assert_req_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !rd_en) |=> !irq_n);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.SRC_N(SRC_N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .evt    (evt),
    .mask_q (mask_q),
    .rdata  (rdata),
    .irq_n  (irq_n)
);

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [3:0] evt = 4'h0;
    logic [7:0] rdata;
    logic       irq_n;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    evt_irq_ctrl #(.SRC_N(4)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .evt(evt), .rdata(rdata), .irq_n(irq_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [7:0] d);
        wr_en = 1'b1; wdata = d;
        step();
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog R1..all actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 irq_n", {7'h0, irq_n}, 8'h01);

        for (int m = 0; m < 16; m++) begin
            for (int e = 1; e < 16; e++) begin
                logic hit;
                hit = ((m & e) != 0);
                wr_mask(8'h7F);
                wr_mask(8'h80 | 8'(m));
                evt = 4'(e);
                step();
                evt = 4'h0;
                // R2 R3 R6: flag positions, summary and request
                chk("R2/R3/R6 rdata", rdata, {hit, 3'b000, 4'(e)});
                chk("R3/R6 irq_n", {7'h0, irq_n}, {7'h0, ~hit});
                // R7: enabling a pending source raises request
                wr_mask(8'h8F);
                chk("R7 irq_n", {7'h0, irq_n}, 8'h00);
                // R10: clearing mask keeps request
                wr_mask(8'h0F);
                chk("R10 irq_n", {7'h0, irq_n}, 8'h00);
                // R8: read returns flags then clears
                rd_en = 1'b1;
                chk("R8 read value", rdata, {1'b1, 3'b000, 4'(e)});
                step();
                rd_en = 1'b0;
                chk("R8 cleared", rdata, 8'h00);
                chk("R8 released", {7'h0, irq_n}, 8'h01);
            end
        end

        // R5: clear only bit 0 of {1,0}
        wr_mask(8'h7F);
        wr_mask(8'h83);
        wr_mask(8'h01);
        evt = 4'h1; step(); evt = 4'h0;
        chk("R5 cleared bit quiet", {7'h0, irq_n}, 8'h01);
        do_read();
        evt = 4'h2; step(); evt = 4'h0;
        chk("R5 kept bit live", {7'h0, irq_n}, 8'h00);
        do_read();
        // R4: successive sets accumulate
        wr_mask(8'h7F);
        wr_mask(8'h81);
        wr_mask(8'h88);
        evt = 4'h1; step(); evt = 4'h0;
        chk("R4 first set kept", rdata, 8'h81);
        do_read();
        evt = 4'h8; step(); evt = 4'h0;
        chk("R4 second set", rdata, 8'h88);
        do_read();
        // R9: event during read survives
        wr_mask(8'h7F);
        wr_mask(8'h84);
        evt = 4'h1; step(); evt = 4'h0;
        chk("R9 pre-read masked", rdata, 8'h01);
        rd_en = 1'b1; evt = 4'h4;
        chk("R9 read value", rdata, 8'h01);
        step();
        rd_en = 1'b0; evt = 4'h0;
        chk("R9 survivor", rdata, 8'h84);
        chk("R9 request", {7'h0, irq_n}, 8'h00);
        do_read();
        chk("R8 final clear", rdata, 8'h00);
        // R1 reset again mid-run
        wr_mask(8'h8F);
        evt = 4'h3; step(); evt = 4'h0;
        rst = 1'b1; step(); rst = 1'b0;
        chk("R1 re-reset", rdata, 8'h00);
        evt = 4'h1; step(); evt = 4'h0;
        chk("R1 mask zero after reset", {7'h0, irq_n}, 8'h01);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule